// File: doc/BRIEF.md
# OTP Register Lock Controller

This block models a bank of one-time-programmable (OTP) words and the lock registers that protect them. A host issues single-cycle program commands. Each command carries a kind (program an OTP word, or program a lock register), a word address and a 16-bit value. Programming can only clear bits. The stored word becomes the bitwise AND of its old contents and the command data. This rule applies to OTP words and to lock registers alike.

The bank has one leading 128-bit register and a parameterised number of further 128-bit user registers. All of them are made of 16-bit words. The lower half of the leading register holds a factory identifier, preset from a parameter, and that half is locked for good. Lock register 0 guards the two halves of the leading register: bit 0 guards the factory half and bit 1 guards the user half. Lock register 1 has one bit per user register. A cleared lock bit can never return to 1.

A refused command leaves all storage unchanged. It raises sticky status flags: a program-error flag, and also a lock-error flag when the refusal was caused by a lock. The flags hold until a clear-status pulse arrives. A combinational read port returns any stored word or lock register by address.

Top module: `otp_lock_ctrl`

## Requirements
- R1: After reset, both status flags and `cmd_done` are 0. Factory words 0x81..0x84 hold `FACTORY_ID` (word 0x81+i = bits 16i+15..16i). All other OTP words read 0xFFFF, lock register 1 reads 0xFFFF and lock register 0 reads 0xFFFE.
- R2: A program-OTP command (`cmd_type`=0) to an unlocked OTP word replaces the word with old AND data. No bit ever returns to 1, and no flag is raised.
- R3: The address map is as follows. Lock register 0 is at 0x80 and lock register 1 is at 0x89. The leading register occupies 0x81..0x88, with its factory half at 0x81..0x84 and its user half at 0x85..0x88. User register k occupies 0x8A+8k..0x8A+8k+7, for k = 0..15. `rd_data` returns the stored value at `rd_addr`, and 0x0000 for any other address.
- R4: A program-OTP command whose address is not an OTP word (this includes 0x80 and 0x89) sets the program-error flag only and changes no storage.
- R5: A program-OTP command to a word whose guarding lock bit is 0 sets both the program-error and the lock-error flags and leaves the word unchanged. The factory half is always locked.
- R6: A program-lock command (`cmd_type`=1) at 0x80 or 0x89 ANDs the data into that lock register. At any other address it sets the program-error flag only and changes nothing.
- R7: Clearing bit 1 of lock register 0 (for example by writing 0xFFFD) locks the words 0x85..0x88 and no others.
- R8: Clearing bit k of lock register 1 locks user register k and no other register.
- R9: Writing a lock register with 1s in bits that are already 0 does not restore those bits. Bit 0 of lock register 0 stays 0 at all times.
- R10: The status flags stay set until `clr_status` is high at a clock edge, and that edge clears both flags. If a refused command arrives at the same edge as `clr_status`, the new error is set and the older state is dropped.
- R11: `cmd_done` is high for exactly the cycle after every command, whatever its outcome, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_type | input | 1 | 0 = program OTP word, 1 = program lock register |
| cmd_addr | input | ADDR_W (9) | Word address of the command |
| cmd_data | input | DATA_W (16) | Value ANDed into the target |
| clr_status | input | 1 | Clears both status flags |
| rd_addr | input | ADDR_W (9) | Read address |
| rd_data | output | DATA_W (16) | Stored word at `rd_addr` (combinational) |
| cmd_done | output | 1 | High the cycle after each command |
| sr_prog_err | output | 1 | Sticky program-error flag |
| sr_lock_err | output | 1 | Sticky lock-error flag |

## Verification
Every effect of a command appears after the single clock edge that samples it: the new word or lock value on `rd_data`, the status flags and `cmd_done` all change at that edge. A clear-status pulse takes effect at its own edge. The bench drives each command on a falling edge and holds the read address on the target. It then samples all outputs at the next falling edge, exactly one rising edge later, and checks the cleared flags one further edge after that. Because `rd_data` is combinational, it is sampled in that same half-cycle, with no extra latency.

// File: rtl/otp_lock_pkg.sv
// Shared types for the OTP lock controller.
// Assumes: one command per cycle, carrying a kind and a word address.
package otp_lock_pkg;

    // Kind of program command on the command port.
    typedef enum logic {
        CMD_PROG_OTP  = 1'b0,
        CMD_PROG_LOCK = 1'b1
    } otp_cmd_e;

    // Error classes a single command can raise.
    typedef struct packed {
        logic prog;
        logic lock;
    } otp_err_t;

endpackage

// File: rtl/otp_addr_decode.sv
// Address classifier: tells whether a word address is a lock register or an
// OTP word, and gives the flat storage index of an OTP word.
// Assumes: the leading register sits right after lock register 0, lock register 1
// follows it, and the user registers follow lock register 1 back to back.
module otp_addr_decode #(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned REG_WORDS  = 8,
    parameter int unsigned NUM_UREG   = 16,
    parameter int unsigned LOCK0_ADDR = 32'h80,
    parameter int unsigned IDX_W      = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_otp,
    output logic              is_lock0,
    output logic              is_lock1,
    output logic [IDX_W-1:0]  word_idx
);
    localparam int unsigned OTP0_BASE  = LOCK0_ADDR + 1;
    localparam int unsigned LOCK1_ADDR = OTP0_BASE + REG_WORDS;
    localparam int unsigned UREG_BASE  = LOCK1_ADDR + 1;
    localparam int unsigned UREG_END   = UREG_BASE + REG_WORDS * NUM_UREG;

    logic [31:0] av;

    // Classify the address and compute the storage index.
    always_comb begin
        av       = 32'(addr);
        is_lock0 = (av == LOCK0_ADDR);
        is_lock1 = (av == LOCK1_ADDR);
        is_otp   = 1'b0;
        word_idx = '0;
        if (av >= OTP0_BASE && av < LOCK1_ADDR) begin
            is_otp   = 1'b1;
            word_idx = IDX_W'(av - OTP0_BASE);
        end else if (av >= UREG_BASE && av < UREG_END) begin
            is_otp   = 1'b1;
            word_idx = IDX_W'(av - UREG_BASE + REG_WORDS);
        end
    end
endmodule

// File: rtl/otp_lock_regs.sv
// The two lock registers. Writes AND the data into the register, so a bit can
// only go from 1 to 0.
// Assumes: write enables come in already qualified; bit 0 of register 0
// resets to 0 (factory lock).
module otp_lock_regs #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr0,
    input  logic              wr1,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] lock0_q,
    output logic [DATA_W-1:0] lock1_q
);
    localparam logic [DATA_W-1:0] LOCK0_RST = {{(DATA_W-1){1'b1}}, 1'b0};

    // Lock register 0: factory bit preset cleared, AND-only updates.
    always_ff @(posedge clk) begin
        if (!rst_n)   lock0_q <= LOCK0_RST;
        else if (wr0) lock0_q <= lock0_q & wdata;
    end

    // Lock register 1: all unlocked at reset, AND-only updates.
    always_ff @(posedge clk) begin
        if (!rst_n)   lock1_q <= '1;
        else if (wr1) lock1_q <= lock1_q & wdata;
    end
endmodule

// File: rtl/otp_word_store.sv
// Flip-flop model of the OTP words. The first ID_WORDS words reset to the
// factory identifier and the rest reset to all ones. A write ANDs the data in.
// Assumes: the caller has already applied the lock and range checks to we.
module otp_word_store #(
    parameter int unsigned DATA_W    = 16,
    parameter int unsigned NUM_WORDS = 136,
    parameter int unsigned IDX_W     = 8,
    parameter int unsigned ID_WORDS  = 4,
    parameter logic [DATA_W*ID_WORDS-1:0] FACTORY_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] word_arr [NUM_WORDS];

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        logic              hit;
        assign hit         = we && (widx == IDX_W'(w));
        assign word_arr[w] = word_q;
        if (w < ID_WORDS) begin : g_fac
            // Factory word: preset from the identifier parameter.
            always_ff @(posedge clk) begin
                if (!rst_n)   word_q <= FACTORY_ID[w*DATA_W +: DATA_W];
                else if (hit) word_q <= word_q & wdata;
            end
        end else begin : g_user
            // User word: erased state is all ones.
            always_ff @(posedge clk) begin
                if (!rst_n)   word_q <= '1;
                else if (hit) word_q <= word_q & wdata;
            end
        end
    end

    // Read the addressed word; an index past the end reads zero.
    always_comb begin
        if (32'(ridx) < NUM_WORDS) rdata = word_arr[ridx];
        else                       rdata = '0;
    end
endmodule

// File: rtl/otp_lock_ctrl.sv
// OTP lock controller top. It takes program commands, decides between accept,
// range error and lock error, updates storage and the sticky status flags,
// and serves a combinational read port.
// Assumes: NUM_UREG <= DATA_W, REG_WORDS is even, and ADDR_W covers the
// whole map.
module otp_lock_ctrl
    import otp_lock_pkg::*;
#(
    parameter int unsigned ADDR_W     = 9,
    parameter int unsigned DATA_W     = 16,
    parameter int unsigned REG_WORDS  = 8,
    parameter int unsigned NUM_UREG   = 16,
    parameter int unsigned LOCK0_ADDR = 32'h80,
    parameter logic [DATA_W*(REG_WORDS/2)-1:0] FACTORY_ID = 64'h1F2E_3D4C_5B6A_7988
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_type,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic              clr_status,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              cmd_done,
    output logic              sr_prog_err,
    output logic              sr_lock_err
);
    localparam int unsigned ID_WORDS  = REG_WORDS / 2;
    localparam int unsigned NUM_WORDS = REG_WORDS * (NUM_UREG + 1);
    localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
    localparam int unsigned NGUARD    = NUM_UREG + 2;
    localparam int unsigned GIDX_W    = $clog2(NGUARD);

    logic              c_otp, c_lock0, c_lock1;
    logic [IDX_W-1:0]  c_idx;
    logic              r_otp, r_lock0, r_lock1;
    logic [IDX_W-1:0]  r_idx;
    logic [GIDX_W-1:0] c_guard;
    logic [NGUARD-1:0] guard_vec;
    logic              c_locked;
    logic [DATA_W-1:0] lock0_q, lock1_q, rd_word;
    logic              otp_we, lk_we0, lk_we1;
    otp_cmd_e          cmd_kind;
    otp_err_t          cmd_err;

    otp_addr_decode #(
        .ADDR_W(ADDR_W), .REG_WORDS(REG_WORDS), .NUM_UREG(NUM_UREG),
        .LOCK0_ADDR(LOCK0_ADDR), .IDX_W(IDX_W)
    ) u_cmd_dec (
        .addr(cmd_addr), .is_otp(c_otp), .is_lock0(c_lock0),
        .is_lock1(c_lock1), .word_idx(c_idx)
    );

    otp_addr_decode #(
        .ADDR_W(ADDR_W), .REG_WORDS(REG_WORDS), .NUM_UREG(NUM_UREG),
        .LOCK0_ADDR(LOCK0_ADDR), .IDX_W(IDX_W)
    ) u_rd_dec (
        .addr(rd_addr), .is_otp(r_otp), .is_lock0(r_lock0),
        .is_lock1(r_lock1), .word_idx(r_idx)
    );

    otp_lock_regs #(.DATA_W(DATA_W)) u_locks (
        .clk(clk), .rst_n(rst_n), .wr0(lk_we0), .wr1(lk_we1),
        .wdata(cmd_data), .lock0_q(lock0_q), .lock1_q(lock1_q)
    );

    otp_word_store #(
        .DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W),
        .ID_WORDS(ID_WORDS), .FACTORY_ID(FACTORY_ID)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .we(otp_we), .widx(c_idx),
        .wdata(cmd_data), .ridx(r_idx), .rdata(rd_word)
    );

    assign cmd_kind  = otp_cmd_e'(cmd_type);
    assign guard_vec = {lock1_q[NUM_UREG-1:0], lock0_q[1:0]};
    assign c_locked  = ~guard_vec[c_guard];

    // Pick the lock bit that guards the commanded word.
    always_comb begin
        if (c_idx < IDX_W'(ID_WORDS))       c_guard = GIDX_W'(0);
        else if (c_idx < IDX_W'(REG_WORDS)) c_guard = GIDX_W'(1);
        else c_guard = GIDX_W'((32'(c_idx) - REG_WORDS) / REG_WORDS + 2);
    end

    // Classify the command as accepted, range error or lock error.
    always_comb begin
        cmd_err = '0;
        otp_we  = 1'b0;
        lk_we0  = 1'b0;
        lk_we1  = 1'b0;
        if (cmd_valid) begin
            if (cmd_kind == CMD_PROG_OTP) begin
                if (!c_otp)        cmd_err.prog = 1'b1;
                else if (c_locked) cmd_err = '{prog: 1'b1, lock: 1'b1};
                else               otp_we = 1'b1;
            end else begin
                if (c_lock0)      lk_we0 = 1'b1;
                else if (c_lock1) lk_we1 = 1'b1;
                else              cmd_err.prog = 1'b1;
            end
        end
    end

    // Sticky flags (a new error beats a clear) and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_prog_err <= 1'b0;
            sr_lock_err <= 1'b0;
            cmd_done    <= 1'b0;
        end else begin
            sr_prog_err <= cmd_err.prog | (sr_prog_err & ~clr_status);
            sr_lock_err <= cmd_err.lock | (sr_lock_err & ~clr_status);
            cmd_done    <= cmd_valid;
        end
    end

    // Read mux over the lock registers and the word store.
    always_comb begin
        if (r_lock0)      rd_data = lock0_q;
        else if (r_lock1) rd_data = lock1_q;
        else if (r_otp)   rd_data = rd_word;
        else              rd_data = '0;
    end
endmodule

// File: rtl/otp_lock_chk.sv
// Assertion checker for otp_lock_ctrl, attached by bind below.
// Assumes: synchronous active-low reset; observes ports and the lock registers.
module otp_lock_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              clr_status,
    input logic              cmd_done,
    input logic              sr_prog_err,
    input logic              sr_lock_err,
    input logic [DATA_W-1:0] lock0_q,
    input logic [DATA_W-1:0] lock1_q
);
    // A lock error always comes with a program error.
    assert_lock_implies_prog_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sr_lock_err |-> sr_prog_err);

    // Lock registers never regain a cleared bit.
    assert_lock0_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock0_q & ~$past(lock0_q)) == '0));
    assert_lock1_monotonic_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((lock1_q & ~$past(lock1_q)) == '0));

    // Factory lock bit is never open.
    assert_factory_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |-> !lock0_q[0]);

    // Flags hold without a clear, and drop with a clear when no command arrives.
    assert_prog_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_prog_err && !clr_status) |=> sr_prog_err);
    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_lock_err && !clr_status) |=> sr_lock_err);
    assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_status && !cmd_valid) |=> (!sr_prog_err && !sr_lock_err));

    // Done pulse follows every command by one cycle and only then.
    assert_done_after_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> cmd_done);
    assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !cmd_done);
endmodule

bind otp_lock_ctrl otp_lock_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .clr_status(clr_status),
    .cmd_done(cmd_done), .sr_prog_err(sr_prog_err), .sr_lock_err(sr_lock_err),
    .lock0_q(lock0_q), .lock1_q(lock1_q)
);

// File: tb/sim_otp_lock_ctrl.sv
// Bench for otp_lock_ctrl. It sweeps every 9-bit address against a model
// built from the requirements.
module sim_otp_lock_ctrl;
    localparam logic [63:0] TB_ID = 64'hC001_D00D_1234_ABCD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0, cmd_type = 1'b0, clr_status = 1'b0;
    logic [8:0]  cmd_addr = '0, rd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic [15:0] rd_data;
    logic        cmd_done, sr_prog_err, sr_lock_err;

    int checks = 0, errors = 0;
    bit finished = 1'b0;
    logic [15:0] model [512];
    bit exp_pe = 1'b0, exp_le = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    otp_lock_ctrl #(.FACTORY_ID(TB_ID)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_type(cmd_type),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .clr_status(clr_status),
        .rd_addr(rd_addr), .rd_data(rd_data), .cmd_done(cmd_done),
        .sr_prog_err(sr_prog_err), .sr_lock_err(sr_lock_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit is_otp_a(input int a);
        return (a >= 'h81 && a <= 'h88) || (a >= 'h8A && a <= 'h109);
    endfunction

    function automatic bit locked_a(input int a);
        if (a <= 'h84) return !model['h80][0];
        if (a <= 'h88) return !model['h80][1];
        return !model['h89][(a - 'h8A) / 8];
    endfunction

    // Issue one command. with_clr raises clr_status in the same cycle;
    // do_clr clears the flags afterwards and checks that they dropped.
    task automatic issue(input bit lk, input int a, input logic [15:0] d,
                         input bit with_clr, input bit do_clr, input string tag);
        bit ep = 0, el = 0;
        string req;
        if (!lk) begin
            if (!is_otp_a(a))    begin ep = 1; req = "R4"; end
            else if (locked_a(a)) begin ep = 1; el = 1; req = "R5"; end
            else begin model[a] = model[a] & d; req = "R2"; end
        end else begin
            req = "R6";
            if (a == 'h80 || a == 'h89) model[a] = model[a] & d;
            else ep = 1;
        end
        if (tag != "") req = tag;
        if (with_clr) begin exp_pe = ep; exp_le = el; end
        else begin exp_pe |= ep; exp_le |= el; end
        @(negedge clk);
        cmd_valid = 1; cmd_type = lk; cmd_addr = 9'(a); cmd_data = d;
        rd_addr = 9'(a); clr_status = with_clr;
        @(negedge clk);
        cmd_valid = 0; clr_status = 0;
        chk("R11", "cmd_done after command", 32'(cmd_done), 1);
        chk(req, "program error flag", 32'(sr_prog_err), 32'(exp_pe));
        chk(req, "lock error flag", 32'(sr_lock_err), 32'(exp_le));
        chk(req, "stored word", 32'(rd_data), 32'(model[a]));
        if (do_clr) begin
            clr_status = 1;
            @(negedge clk);
            clr_status = 0;
            exp_pe = 0; exp_le = 0;
            chk("R10", "program flag after clear", 32'(sr_prog_err), 0);
            chk("R10", "lock flag after clear", 32'(sr_lock_err), 0);
            chk("R11", "cmd_done idle", 32'(cmd_done), 0);
        end
    endtask

    task automatic read_sweep(input string req);
        for (int a = 0; a < 512; a++) begin
            @(negedge clk);
            rd_addr = 9'(a);
            #1;
            chk(req, $sformatf("read 0x%0h", a), 32'(rd_data), 32'(model[a]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Model the reset state (R1).
        for (int a = 0; a < 512; a++) model[a] = is_otp_a(a) ? 16'hFFFF : 16'h0000;
        for (int i = 0; i < 4; i++) model['h81 + i] = TB_ID[16*i +: 16];
        model['h80] = 16'hFFFE;
        model['h89] = 16'hFFFF;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "cmd_done at reset", 32'(cmd_done), 0);
        chk("R1", "program flag at reset", 32'(sr_prog_err), 0);
        chk("R1", "lock flag at reset", 32'(sr_lock_err), 0);
        read_sweep("R1");

        // Pass 1 (R2, R4, R5): program every address with a mixed pattern.
        for (int a = 0; a < 512; a++) issue(0, a, 16'(a * 37) ^ 16'hA5C3, 0, 1, "");
        // Pass 2 (R2): clear one more bit per word; earlier zeros stay.
        for (int a = 0; a < 512; a++) issue(0, a, ~(16'h1 << (a % 16)), 0, 1, "");

        // Lock writes at a wrong address and as an OTP kind at a lock address (R6, R4).
        issue(1, 'h81, 16'h0000, 0, 1, "R6");
        issue(1, 'h8A, 16'h0000, 0, 1, "R6");
        issue(0, 'h80, 16'h0000, 0, 1, "R4");
        issue(0, 'h89, 16'h0000, 0, 1, "R4");

        // Lock the user half of the leading register (R7).
        issue(1, 'h80, 16'hFFFD, 0, 1, "R7");
        issue(0, 'h85, 16'h0000, 0, 1, "R7");
        issue(0, 'h88, 16'h0000, 0, 1, "R7");
        issue(0, 'h84, 16'h0000, 0, 1, "R5");
        issue(0, 'h8A, 16'hFFF0, 0, 1, "R7");

        // Lock user registers 3 and 15 only (R8).
        issue(1, 'h89, 16'hFFF7, 0, 1, "R8");
        issue(1, 'h89, 16'h7FFF, 0, 1, "R8");
        issue(0, 'hA2, 16'h0000, 0, 1, "R8");
        issue(0, 'hA9, 16'h0000, 0, 1, "R8");
        issue(0, 'hA1, 16'h00FF, 0, 1, "R8");
        issue(0, 'hAA, 16'h00FF, 0, 1, "R8");
        issue(0, 'h109, 16'h0000, 0, 1, "R8");

        // Try to reopen locks (R9).
        issue(1, 'h80, 16'hFFFF, 0, 1, "R9");
        issue(1, 'h89, 16'hFFFF, 0, 1, "R9");
        issue(1, 'h80, 16'hFFFB, 0, 1, "R9");

        // Sticky flags and clear collisions (R10).
        issue(0, 'h0, 16'h0000, 0, 0, "R10");
        issue(0, 'h90, 16'hFFFE, 0, 0, "R10");
        repeat (3) @(negedge clk);
        chk("R10", "program flag held", 32'(sr_prog_err), 1);
        issue(0, 'h84, 16'h0000, 0, 0, "R10");
        issue(0, 'h1FF, 16'h0000, 1, 0, "R10");
        issue(0, 'h91, 16'hFFFF, 1, 1, "R10");

        // Pass 3 (R2, R4, R5): zero everything; locked regions must survive.
        for (int a = 0; a < 512; a++) issue(0, a, 16'h0000, 0, 1, "");
        read_sweep("R3");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule